// File: doc/BRIEF.md
# Two-Pass Wide-Register Integer Execution Unit

This unit executes integer operations on a bank of double-width registers with a datapath only half as wide. Each register is kept as two half-width rows in one deep, narrow store. An operation on a full register runs through the half-width ALU twice: first on the low halves, then on the high halves. The carry or borrow from the first pass is carried into the second. A half-width operation runs once, touches only the low half and leaves the high half as it was. Two immediate-load operations fill one half of a register. They let a register be seeded or patched without a wider path.

A caller places an operation code, a full/half flag, a destination, two source register numbers and an immediate on the inputs. It then raises `start` for one cycle. The unit reports `busy` while it works. Every row write is visible on a write-back bus. `done` pulses once when the operation ends, and at that point `carry_out` holds the carry from the most recent arithmetic pass. With the default parameters the unit has 32 registers of 128 bits, a 64-bit ALU and a 64-row store.

Top module: `wra_exec`

## Requirements
- R1: The store has 2*NREGS rows of HALF_W bits. A row address is the half-select bit (1 = high half) placed above the register number, and `wb_row` shows that address for every write.
- R2: A full-width add (op code 0, `wide`=1) makes two writes. The first write is the low half and the second is the high half. The result is (a+b) mod 2^(2*HALF_W), and `carry_out` is the carry out of the top bit.
- R3: A subtract (op code 1) computes a-b with the borrow of the low pass fed into the high pass. `carry_out` is 1 exactly when no borrow occurred, that is when a >= b over the operated width.
- R4: The bitwise op codes are 2 (and), 3 (or) and 4 (xor). They produce the bitwise result, take no carry and leave `carry_out` unchanged.
- R5: Op codes 0 to 4 with `wide`=0 make exactly one write, to the low half. They leave the stored high half of the destination unchanged.
- R6: Op code 5 writes `imm` into the low half of the destination and op code 6 writes it into the high half. Each makes one write whatever the value of `wide`. Op code 7 makes no write.
- R7: `done` is high for exactly one cycle, and only in the cycle after the final pass. Counted from the cycle in which `start` is seen, a two-pass operation raises `done` 3 cycles later and any other operation raises it 2 cycles later.
- R8: `start` has no effect while `busy` is high. No extra write occurs, and the register named by the ignored request keeps its value.
- R9: An operation started in the cycle in which `done` is high reads the result of the operation that just finished.
- R10: During and straight after reset, `busy`, `done` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code |
| wide | input | 1 | 1 = full-register operation, 0 = low half only |
| rd | input | log2(NREGS) | Destination register |
| rs1 | input | log2(NREGS) | First source register |
| rs2 | input | log2(NREGS) | Second source register |
| imm | input | HALF_W | Immediate for the load operations |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | A row is written this cycle |
| wb_row | output | log2(NREGS)+1 | Row being written |
| wb_data | output | HALF_W | Data being written |
| carry_out | output | 1 | Carry/no-borrow of the last arithmetic pass |

## Verification
The bench builds the unit with HALF_W=4 and NREGS=4, which makes each register 8 bits. This makes every pair of low-half operands reachable: all 256 combinations are swept, with high halves derived from them. Every carry and borrow crossing between the passes is therefore exercised, and full-width sums and differences are checked against 8-bit arithmetic. A full-width OR of a register with itself reads each register back through the write-back bus. This shows that the high halves survive half-width operations and ignored requests.

// File: rtl/wra_pkg.sv
package wra_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4,
      OP_LDL = 3'd5,
      OP_LDH = 3'd6,
      OP_NOP = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2
   } st_e;
endpackage

// File: rtl/wra_regfile.sv
module wra_regfile #(
   parameter int W      = 64,
   parameter int ROWS   = 64,
   parameter int NRD    = 2,
   parameter bit BYPASS = 1'b1,
   parameter int AW     = $clog2(ROWS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [AW-1:0]            wa,
   input  logic [W-1:0]             wd,
   input  logic [NRD-1:0][AW-1:0]   ra,
   output logic [NRD-1:0][W-1:0]    rdat
);
   initial begin
      assert (W >= 1 && NRD >= 1);
      assert (ROWS <= (1 << AW));
   end

   logic [W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
   end

   for (genvar gp = 0; gp < NRD; gp++) begin : g_rd
      logic [W-1:0] q;
      if (BYPASS) begin : g_byp
         always_ff @(posedge clk) begin
            q <= (we && wa == ra[gp]) ? wd : mem[ra[gp]];
         end
         AST_RD_NEWDATA: assert property (@(posedge clk) disable iff (!rst_n)
            $past(we && wa == ra[gp]) |-> q == $past(wd)); // R9
      end else begin : g_plain
         always_ff @(posedge clk) begin
            q <= mem[ra[gp]];
         end
      end
      assign rdat[gp] = q;
   end
endmodule

// File: rtl/wra_alu.sv
module wra_alu
   import wra_pkg::*;
#(
   parameter int W = 64
) (
   input  op_e          op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] y,
   output logic         cout
);
   logic [W:0]   sum;
   logic [W-1:0] b_eff;

   always_comb begin
      b_eff = (op == OP_SUB) ? ~b : b;
      sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
      cout  = sum[W];
      unique case (op)
         OP_ADD, OP_SUB: y = sum[W-1:0];
         OP_AND:         y = a & b;
         OP_OR:          y = a | b;
         OP_XOR:         y = a ^ b;
         default:        y = '0;
      endcase
   end
endmodule

// File: rtl/wra_seq.sv
module wra_seq
   import wra_pkg::*;
#(
   parameter int RAW = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  op_e            op,
   input  logic           wide,
   input  logic [RAW-1:0] rd,
   input  logic [RAW-1:0] rs1,
   input  logic [RAW-1:0] rs2,
   output st_e            state,
   output logic           accept,
   output logic           done,
   output op_e            op_q,
   output logic [RAW-1:0] rd_q,
   output logic [RAW-1:0] rs1_q,
   output logic [RAW-1:0] rs2_q
);
   logic wide_q;
   logic two_pass;

   assign accept   = (state == ST_IDLE) && start;
   assign two_pass = wide_q && (op_q inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         done   <= 1'b0;
         op_q   <= OP_NOP;
         wide_q <= 1'b0;
         rd_q   <= '0;
         rs1_q  <= '0;
         rs2_q  <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state  <= ST_LO;
               op_q   <= op;
               wide_q <= wide;
               rd_q   <= rd;
               rs1_q  <= rs1;
               rs2_q  <= rs2;
            end
            ST_LO: if (two_pass) begin
               state <= ST_HI;
            end else begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end
            default: begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end
         endcase
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(state) != ST_IDLE); // R7
   AST_LO_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LO) |-> $past(state) == ST_IDLE); // R8
   AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HI) |-> $past(state) == ST_LO); // R2
endmodule

// File: rtl/wra_exec.sv
module wra_exec
   import wra_pkg::*;
#(
   parameter int HALF_W = 64,
   parameter int NREGS  = 32,
   parameter bit BYPASS = 1'b1,
   localparam int RAW   = $clog2(NREGS),
   localparam int ROWAW = RAW + 1,
   localparam int ROWS  = 2 * NREGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic              wide,
   input  logic [RAW-1:0]    rd,
   input  logic [RAW-1:0]    rs1,
   input  logic [RAW-1:0]    rs2,
   input  logic [HALF_W-1:0] imm,
   output logic              busy,
   output logic              done,
   output logic              wb_en,
   output logic [ROWAW-1:0]  wb_row,
   output logic [HALF_W-1:0] wb_data,
   output logic              carry_out
);
   initial begin
      assert (HALF_W >= 2);
      assert (NREGS >= 2 && (1 << RAW) == NREGS);
   end

   st_e                         state;
   logic                        accept;
   op_e                         op_q;
   logic [RAW-1:0]              rd_q, rs1_q, rs2_q;
   logic [HALF_W-1:0]           imm_q;
   logic                        carry_q;
   logic [1:0][ROWAW-1:0]       rd_addr;
   logic [1:0][HALF_W-1:0]      rd_data;
   logic [HALF_W-1:0]           alu_y;
   logic                        alu_cout;
   logic                        alu_cin;
   logic                        is_arith;
   logic                        is_load;

   wra_seq #(.RAW(RAW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_e'(op)), .wide(wide),
      .rd(rd), .rs1(rs1), .rs2(rs2), .state(state), .accept(accept), .done(done),
      .op_q(op_q), .rd_q(rd_q), .rs1_q(rs1_q), .rs2_q(rs2_q)
   );

   // Low-half rows are fetched as the request is taken; high-half rows during the low pass.
   assign rd_addr[0] = (state == ST_IDLE) ? {1'b0, rs1} : {1'b1, rs1_q};
   assign rd_addr[1] = (state == ST_IDLE) ? {1'b0, rs2} : {1'b1, rs2_q};

   wra_regfile #(.W(HALF_W), .ROWS(ROWS), .NRD(2), .BYPASS(BYPASS), .AW(ROWAW)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(wb_en), .wa(wb_row), .wd(wb_data),
      .ra(rd_addr), .rdat(rd_data)
   );

   assign is_arith = (op_q == OP_ADD) || (op_q == OP_SUB);
   assign is_load  = (op_q == OP_LDL) || (op_q == OP_LDH);
   assign alu_cin  = (state == ST_HI) ? carry_q : (op_q == OP_SUB);

   wra_alu #(.W(HALF_W)) u_alu (
      .op(op_q), .a(rd_data[0]), .b(rd_data[1]), .cin(alu_cin),
      .y(alu_y), .cout(alu_cout)
   );

   assign busy    = (state != ST_IDLE);
   assign wb_en   = busy && (op_q != OP_NOP);
   assign wb_row  = {(state == ST_HI) || (op_q == OP_LDH), rd_q};
   assign wb_data = is_load ? imm_q : alu_y;
   assign carry_out = carry_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imm_q   <= '0;
         carry_q <= 1'b0;
      end else begin
         if (accept) imm_q <= imm;
         if (busy && is_arith) carry_q <= alu_cout;
      end
   end

   AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (op_q inside {OP_AND, OP_OR, OP_XOR})) |=> $stable(carry_q)); // R4
   AST_HI_PASS_HI_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HI) |-> wb_row[RAW]); // R1
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wb_en); // R10
endmodule

// File: tb/wra_exec_tb.sv
module wra_exec_tb;
   localparam int HW  = 4;
   localparam int NR  = 4;
   localparam int RAW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    op = '0;
   logic          wide = 1'b0;
   logic [RAW-1:0] rd = '0, rs1 = '0, rs2 = '0;
   logic [HW-1:0] imm = '0;
   logic          busy, done, wb_en, carry_out;
   logic [RAW:0]  wb_row;
   logic [HW-1:0] wb_data;

   int checks = 0;
   int errs   = 0;
   logic [2*HW-1:0] mreg [NR];
   logic mc = 1'b0;

   always #2.5 clk = ~clk;

   wra_exec #(.HALF_W(HW), .NREGS(NR)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
      .rd(rd), .rs1(rs1), .rs2(rs2), .imm(imm), .busy(busy), .done(done),
      .wb_en(wb_en), .wb_row(wb_row), .wb_data(wb_data), .carry_out(carry_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Runs one operation starting at the current negedge; returns at the negedge where done is high.
   task automatic do_op(input logic [2:0] o, input logic w, input logic [1:0] d, s1, s2,
                        input logic [3:0] im, input string tag);
      logic [7:0] a, b, e, got;
      logic [8:0] f;
      logic [4:0] f5;
      logic ec, multi, first_hi;
      int nw, nw_exp, lat_exp, cyc;
      a = mreg[s1]; b = mreg[s2]; e = mreg[d]; ec = mc;
      multi = w && (o <= 3'd4);
      case (o)
         3'd0: if (multi) begin f = {1'b0, a} + {1'b0, b}; e = f[7:0]; ec = f[8]; end
               else begin f5 = {1'b0, a[3:0]} + {1'b0, b[3:0]}; e[3:0] = f5[3:0]; ec = f5[4]; end
         3'd1: if (multi) begin e = a - b; ec = (a >= b); end
               else begin e[3:0] = a[3:0] - b[3:0]; ec = (a[3:0] >= b[3:0]); end
         3'd2: if (multi) e = a & b; else e[3:0] = a[3:0] & b[3:0];
         3'd3: if (multi) e = a | b; else e[3:0] = a[3:0] | b[3:0];
         3'd4: if (multi) e = a ^ b; else e[3:0] = a[3:0] ^ b[3:0];
         3'd5: e[3:0] = im;
         3'd6: e[7:4] = im;
         default: ;
      endcase
      nw_exp  = (o == 3'd7) ? 0 : (multi ? 2 : 1);
      lat_exp = multi ? 3 : 2;
      op = o; wide = w; rd = d; rs1 = s1; rs2 = s2; imm = im; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1; nw = 0; got = mreg[d]; first_hi = 1'b0;
      while (!done && cyc < 12) begin
         if (wb_en) begin
            nw++;
            if (nw == 1) first_hi = wb_row[RAW];
            chk(wb_row[RAW-1:0] == d, "R1", int'(wb_row), int'(d));
            if (wb_row[RAW]) got[7:4] = wb_data; else got[3:0] = wb_data;
         end
         @(negedge clk);
         cyc++;
      end
      chk(got == e, tag, got, e);
      chk(nw == nw_exp, multi ? "R2" : (o >= 3'd5 ? "R6" : "R5"), nw, nw_exp);
      chk(cyc == lat_exp, "R7", cyc, lat_exp);
      if (multi) chk(first_hi == 1'b0, "R2", first_hi, 0);
      if (o == 3'd0 || o == 3'd1) chk(carry_out == ec, o == 3'd0 ? "R2" : "R3", carry_out, ec);
      else chk(carry_out == ec, "R4", carry_out, ec);
      mreg[d] = e; mc = ec;
   endtask

   task automatic readback(input logic [1:0] r, input string tag);
      do_op(3'd3, 1'b1, r, r, r, 4'd0, tag);
   endtask

   initial begin
      for (int i = 0; i < NR; i++) mreg[i] = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !wb_en, "R10", {busy, done, wb_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !wb_en, "R10", {busy, done, wb_en}, 0);
      chk(carry_out == 1'b0, "R10", carry_out, 0);

      for (int al = 0; al < 16; al++) begin
         for (int bl = 0; bl < 16; bl++) begin
            do_op(3'd5, 1'b0, 2'd1, 2'd0, 2'd0, 4'(al), "R6");
            do_op(3'd6, 1'b1, 2'd1, 2'd0, 2'd0, 4'(al * 3 + 1), "R6");
            do_op(3'd5, 1'b1, 2'd2, 2'd0, 2'd0, 4'(bl), "R6");
            do_op(3'd6, 1'b0, 2'd2, 2'd0, 2'd0, 4'(bl * 7 + 2), "R6");
            // R9: sources were written by the operation that finished in the start cycle
            do_op(3'd0, 1'b1, 2'd3, 2'd1, 2'd2, 4'd0, "R9");
            do_op(3'd1, 1'b1, 2'd0, 2'd1, 2'd2, 4'd0, "R3");
            do_op(3'd0, 1'b0, 2'd3, 2'd2, 2'd1, 4'd0, "R5");
            readback(2'd3, "R5");
            do_op(3'd2, 1'b1, 2'd0, 2'd1, 2'd2, 4'd0, "R4");
            do_op(3'd4, 1'b0, 2'd3, 2'd3, 2'd1, 4'd0, "R4");
            do_op(3'd3, 1'b0, 2'd0, 2'd2, 2'd1, 4'd0, "R4");
            do_op(3'd1, 1'b0, 2'd2, 2'd1, 2'd2, 4'd0, "R3");
            readback(2'd2, "R5");
            do_op(3'd7, 1'b1, 2'd1, 2'd0, 2'd0, 4'hF, "R6");
            do_op(3'd0, 1'b1, 2'd1, 2'd3, 2'd0, 4'd0, "R2");
            do_op(3'd4, 1'b1, 2'd3, 2'd0, 2'd1, 4'd0, "R4");
         end
      end

      // R8: a second request during a two-pass add is dropped
      begin
         logic [7:0] e3;
         logic [7:0] gotw;
         int nw;
         e3 = mreg[1] + mreg[2];
         op = 3'd0; wide = 1'b1; rd = 2'd3; rs1 = 2'd1; rs2 = 2'd2; start = 1'b1;
         @(negedge clk);
         nw = 0; gotw = mreg[3];
         if (wb_en) begin nw++; gotw[3:0] = wb_data; end
         op = 3'd5; wide = 1'b0; rd = 2'd0; imm = ~mreg[0][3:0]; start = 1'b1;
         @(negedge clk);
         if (wb_en) begin nw++; if (wb_row[RAW]) gotw[7:4] = wb_data; else gotw[3:0] = wb_data; end
         start = 1'b0;
         @(negedge clk);
         chk(done == 1'b1, "R7", done, 1);
         chk(busy == 1'b0, "R8", busy, 0);
         chk(nw == 2, "R8", nw, 2);
         chk(gotw == e3, "R8", gotw, e3);
         mreg[3] = e3;
         mc = ({1'b0, mreg[1]} + {1'b0, mreg[2]}) >> 8;
         @(negedge clk);
         chk(done == 1'b0, "R7", done, 0);
         chk(wb_en == 1'b0 && busy == 1'b0, "R8", {wb_en, busy}, 0);
         readback(2'd0, "R8");
         readback(2'd3, "R2");
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule